// File: doc/BRIEF.md
# Dual Granularity Sparing Controller

This block redirects faulty regions of a stacked memory to spare storage, using one of two sparing units. An upstream classifier sends fault reports with a location (bank, row) and a class code. Fine-grained faults (bit, word, row) each claim one entry from a small pool of spare rows. Coarse faults (column, bank) each claim a whole spare bank, which sits on the separate ECC die. Each fault report takes effect in the cycle it arrives, and every later memory request is translated against the updated table.

A request (bank, row, column) gets a registered response one cycle later. The response holds a target code and the translated bank and row. The column always passes through unchanged. Bank remaps take priority over row remaps. When a bank is spared, any row spares already allocated inside it are freed for reuse. A row fault inside a bank that is already spared, or a repeat report of a row that is already spared, uses no new entry. When no free spare of the needed kind exists, a sticky flag is raised and the faulty location stays untranslated.

Top module: `dgs_remap_ctrl`

## Requirements
- R1: While reset is low and after it is released: no response is valid, both exhausted flags are 0, and every remap entry is cleared, so every request maps to the data array.
- R2: A request sampled at a clock edge produces o_rsp_valid=1 after that same edge, for exactly one cycle. The column is copied through unchanged. An address with no remap returns target code 0 (data array) with its bank and row unchanged. Target code 3 never appears.
- R3: A fault with class code 0 (bit), 1 (word) or 2 (row) claims the lowest-numbered free spare-row entry for its (bank, row). Later requests to that exact bank and row return target code 1, bank 0, and row = entry index. Other rows in the same bank are not translated.
- R4: A fault with class code 3 (column) or 4 (bank) claims the lowest-numbered free spare bank. Later requests to any row of that bank return target code 2, bank = spare index, and the row unchanged.
- R5: When an address matches both a spare bank and a spare row, the spare bank wins.
- R6: A small-class fault in a bank that already has a spare bank uses no spare-row entry.
- R7: A small-class fault on a (bank, row) that already holds a spare-row entry uses no new entry.
- R8: Sparing a bank frees every spare-row entry whose bank matches it, in the same cycle. Freed entries are reused lowest index first.
- R9: A small-class fault that needs a new entry when none is free sets the sticky o_row_exhausted flag. Its address stays untranslated, and existing entries keep working.
- R10: A large-class fault on a bank with no spare, when no spare bank is free, sets the sticky o_bank_exhausted flag. That bank stays untranslated, and its existing row entries keep working.
- R11: Fault reports with class codes 5 to 7 change nothing.
- R12: A fault report and a request in the same cycle: the request is translated with the table as it was before that fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_flt_valid | input | 1 | Fault report strobe |
| i_flt_class | input | 3 | Fault class code (0 bit, 1 word, 2 row, 3 column, 4 bank) |
| i_flt_bank | input | BANK_W | Bank of the faulty location |
| i_flt_row | input | ROW_W | Row of the faulty location |
| i_req_valid | input | 1 | Request strobe |
| i_req_bank | input | BANK_W | Request bank |
| i_req_row | input | ROW_W | Request row |
| i_req_col | input | COL_W | Request column |
| o_rsp_valid | output | 1 | Translated address valid |
| o_rsp_tgt | output | 2 | Target: 0 data array, 1 spare row, 2 spare bank |
| o_rsp_bank | output | BANK_W | Translated bank (spare index for target 2, 0 for target 1) |
| o_rsp_row | output | ROW_W | Translated row (entry index for target 1) |
| o_rsp_col | output | COL_W | Column, passed through |
| o_row_exhausted | output | 1 | Sticky: a small fault found no free spare row |
| o_bank_exhausted | output | 1 | Sticky: a large fault found no free spare bank |

## Verification
Translation is exercised with a sequence of patterns. Requests to unmapped addresses check the pass-through. Requests to an exact spared row and to a neighbouring row in the same bank separate row-level from bank-level matching. Requests to several rows of a spared bank check that the whole bank is covered. Duplicate reports, reports inside spared banks and reports with illegal class codes are detected through the entry index that the next genuine fault receives. Bank sparing that frees row entries, filling both pools, and a fault arriving in the same cycle as a request check release order, the exhausted flags and the one-cycle update ordering.

// File: rtl/dgs_pkg.sv
// Shared codes for the dual granularity sparing controller.
// Assumes the fault classifier upstream uses the class encoding below.
package dgs_pkg;

    typedef enum logic [2:0] {
        FC_BIT    = 3'd0,
        FC_WORD   = 3'd1,
        FC_ROW    = 3'd2,
        FC_COLUMN = 3'd3,
        FC_BANK   = 3'd4
    } fault_cls_e;

    typedef enum logic [1:0] {
        TGT_DATA       = 2'd0,
        TGT_SPARE_ROW  = 2'd1,
        TGT_SPARE_BANK = 2'd2
    } tgt_e;

    // True for the classes retired by a single spare row
    function automatic logic cls_is_small(input logic [2:0] cls);
        return (cls == FC_BIT) || (cls == FC_WORD) || (cls == FC_ROW);
    endfunction

    // True for the classes retired by a whole spare bank
    function automatic logic cls_is_large(input logic [2:0] cls);
        return (cls == FC_COLUMN) || (cls == FC_BANK);
    endfunction

endpackage

// File: rtl/dgs_first_free.sv
// Lowest-index finder: reports whether any bit is set and the index of
// the lowest set bit. Used to pick free entries and to encode matches.
// Assumes N >= 1; the index is 0 when no bit is set.
module dgs_first_free #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top so that the lowest set bit wins
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/dgs_spare_table.sv
// Fully associative remap table of ENTRIES tags. Provides one lookup port
// for requests, one probe port for incoming faults, lowest-free allocation
// and bulk release of all entries whose upper REL_W tag bits match a key.
// Assumes alloc and release are never requested in the same cycle, and
// that alloc is only raised while free_found_o is high.
module dgs_spare_table #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 12,
    parameter int REL_W   = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    input  logic             rel_en_i,
    input  logic [REL_W-1:0] rel_key_i,
    input  logic [TAG_W-1:0] look_tag_i,
    output logic             look_hit_o,
    output logic [IDX_W-1:0] look_idx_o,
    input  logic [TAG_W-1:0] probe_tag_i,
    output logic             probe_hit_o,
    output logic             free_found_o,
    output logic [IDX_W-1:0] free_idx_o
);

    logic             valid_q [ENTRIES];
    logic [TAG_W-1:0] tag_q   [ENTRIES];
    logic [ENTRIES-1:0] look_vec;
    logic [ENTRIES-1:0] probe_vec;
    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] rel_vec;
    logic [IDX_W-1:0]   probe_idx_unused;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Per-entry match, free and release conditions
        always_comb begin
            look_vec[g]  = valid_q[g] && (tag_q[g] == look_tag_i);
            probe_vec[g] = valid_q[g] && (tag_q[g] == probe_tag_i);
            free_vec[g]  = !valid_q[g];
            rel_vec[g]   = rel_en_i && valid_q[g] &&
                           (tag_q[g][TAG_W-1 -: REL_W] == rel_key_i);
        end

        // Per-entry state: clear on reset or release, fill on allocation
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
            end else if (rel_vec[g]) begin
                valid_q[g] <= 1'b0;
            end else if (alloc_en_i && (free_idx_o == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= alloc_tag_i;
            end
        end
    end

    dgs_first_free #(.N(ENTRIES)) u_free (
        .vec_i   (free_vec),
        .found_o (free_found_o),
        .idx_o   (free_idx_o)
    );

    dgs_first_free #(.N(ENTRIES)) u_look (
        .vec_i   (look_vec),
        .found_o (look_hit_o),
        .idx_o   (look_idx_o)
    );

    dgs_first_free #(.N(ENTRIES)) u_probe (
        .vec_i   (probe_vec),
        .found_o (probe_hit_o),
        .idx_o   (probe_idx_unused)
    );

endmodule

// File: rtl/dgs_remap_ctrl.sv
// Dual granularity sparing controller. Small-class faults claim a spare
// row, large-class faults claim a spare bank; requests are translated one
// cycle after they are sampled, bank remaps taking priority over row remaps.
// Assumes at most one fault report per cycle, ROW_SPARES fits in ROW_W
// bits and BANK_SPARES fits in BANK_W bits.
module dgs_remap_ctrl
    import dgs_pkg::*;
#(
    parameter int BANK_W      = 4,
    parameter int ROW_W       = 8,
    parameter int COL_W       = 6,
    parameter int ROW_SPARES  = 8,
    parameter int BANK_SPARES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_flt_valid,
    input  logic [2:0]        i_flt_class,
    input  logic [BANK_W-1:0] i_flt_bank,
    input  logic [ROW_W-1:0]  i_flt_row,
    input  logic              i_req_valid,
    input  logic [BANK_W-1:0] i_req_bank,
    input  logic [ROW_W-1:0]  i_req_row,
    input  logic [COL_W-1:0]  i_req_col,
    output logic              o_rsp_valid,
    output logic [1:0]        o_rsp_tgt,
    output logic [BANK_W-1:0] o_rsp_bank,
    output logic [ROW_W-1:0]  o_rsp_row,
    output logic [COL_W-1:0]  o_rsp_col,
    output logic              o_row_exhausted,
    output logic              o_bank_exhausted
);

    localparam int RS_IDX_W  = (ROW_SPARES > 1) ? $clog2(ROW_SPARES) : 1;
    localparam int BS_IDX_W  = (BANK_SPARES > 1) ? $clog2(BANK_SPARES) : 1;
    localparam int ROW_TAG_W = BANK_W + ROW_W;

    // Row spare table signals
    logic                row_look_hit;
    logic [RS_IDX_W-1:0] row_look_idx;
    logic                row_probe_hit;
    logic                row_free;
    logic [RS_IDX_W-1:0] row_free_idx;
    // Bank spare table signals
    logic                bank_look_hit;
    logic [BS_IDX_W-1:0] bank_look_idx;
    logic                bank_probe_hit;
    logic                bank_free;
    logic [BS_IDX_W-1:0] bank_free_idx;
    // Fault decisions
    logic flt_small, flt_large;
    logic row_alloc, row_short;
    logic bank_alloc, bank_short;
    // Response next-state
    logic [1:0]        tgt_d;
    logic [BANK_W-1:0] bank_d;
    logic [ROW_W-1:0]  row_d;

    // Classify the incoming fault and decide what it claims
    always_comb begin
        flt_small  = i_flt_valid && cls_is_small(i_flt_class);
        flt_large  = i_flt_valid && cls_is_large(i_flt_class);
        row_alloc  = flt_small && !bank_probe_hit && !row_probe_hit && row_free;
        row_short  = flt_small && !bank_probe_hit && !row_probe_hit && !row_free;
        bank_alloc = flt_large && !bank_probe_hit && bank_free;
        bank_short = flt_large && !bank_probe_hit && !bank_free;
    end

    dgs_spare_table #(
        .ENTRIES (ROW_SPARES),
        .TAG_W   (ROW_TAG_W),
        .REL_W   (BANK_W)
    ) u_row_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en_i   (row_alloc),
        .alloc_tag_i  ({i_flt_bank, i_flt_row}),
        .rel_en_i     (bank_alloc),
        .rel_key_i    (i_flt_bank),
        .look_tag_i   ({i_req_bank, i_req_row}),
        .look_hit_o   (row_look_hit),
        .look_idx_o   (row_look_idx),
        .probe_tag_i  ({i_flt_bank, i_flt_row}),
        .probe_hit_o  (row_probe_hit),
        .free_found_o (row_free),
        .free_idx_o   (row_free_idx)
    );

    dgs_spare_table #(
        .ENTRIES (BANK_SPARES),
        .TAG_W   (BANK_W),
        .REL_W   (BANK_W)
    ) u_bank_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en_i   (bank_alloc),
        .alloc_tag_i  (i_flt_bank),
        .rel_en_i     (1'b0),
        .rel_key_i    (i_flt_bank),
        .look_tag_i   (i_req_bank),
        .look_hit_o   (bank_look_hit),
        .look_idx_o   (bank_look_idx),
        .probe_tag_i  (i_flt_bank),
        .probe_hit_o  (bank_probe_hit),
        .free_found_o (bank_free),
        .free_idx_o   (bank_free_idx)
    );

    // Translate the request: bank remap first, then row remap, else pass
    always_comb begin
        tgt_d  = TGT_DATA;
        bank_d = i_req_bank;
        row_d  = i_req_row;
        if (bank_look_hit) begin
            tgt_d  = TGT_SPARE_BANK;
            bank_d = BANK_W'(bank_look_idx);
        end else if (row_look_hit) begin
            tgt_d  = TGT_SPARE_ROW;
            bank_d = '0;
            row_d  = ROW_W'(row_look_idx);
        end
    end

    // Register the translated response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_rsp_valid <= 1'b0;
            o_rsp_tgt   <= TGT_DATA;
            o_rsp_bank  <= '0;
            o_rsp_row   <= '0;
            o_rsp_col   <= '0;
        end else begin
            o_rsp_valid <= i_req_valid;
            if (i_req_valid) begin
                o_rsp_tgt  <= tgt_d;
                o_rsp_bank <= bank_d;
                o_rsp_row  <= row_d;
                o_rsp_col  <= i_req_col;
            end
        end
    end

    // Sticky exhaustion flags, raised when a fault finds no free spare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_row_exhausted  <= 1'b0;
            o_bank_exhausted <= 1'b0;
        end else begin
            if (row_short)  o_row_exhausted  <= 1'b1;
            if (bank_short) o_bank_exhausted <= 1'b1;
        end
    end

    // The free index is consumed inside the tables; kept visible for debug
    logic unused_free_idx;
    assign unused_free_idx = ^{row_free_idx, bank_free_idx};

endmodule

// File: rtl/dgs_checker.sv
// Property checker for dgs_remap_ctrl, attached through bind. Observes
// ports only; assumes the synchronous active-low reset of the design.
module dgs_checker #(
    parameter int BANK_W      = 4,
    parameter int ROW_W       = 8,
    parameter int COL_W       = 6,
    parameter int ROW_SPARES  = 8,
    parameter int BANK_SPARES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              i_flt_valid,
    input logic [2:0]        i_flt_class,
    input logic [BANK_W-1:0] i_flt_bank,
    input logic [ROW_W-1:0]  i_flt_row,
    input logic              i_req_valid,
    input logic [BANK_W-1:0] i_req_bank,
    input logic [ROW_W-1:0]  i_req_row,
    input logic [COL_W-1:0]  i_req_col,
    input logic              o_rsp_valid,
    input logic [1:0]        o_rsp_tgt,
    input logic [BANK_W-1:0] o_rsp_bank,
    input logic [ROW_W-1:0]  o_rsp_row,
    input logic [COL_W-1:0]  o_rsp_col,
    input logic              o_row_exhausted,
    input logic              o_bank_exhausted
);

    logic unused_in;
    assign unused_in = ^{i_flt_bank, i_flt_row};

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!o_rsp_valid && !o_row_exhausted && !o_bank_exhausted));

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        i_req_valid |=> o_rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !i_req_valid |=> !o_rsp_valid);

    assert_col_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        i_req_valid |=> (o_rsp_col == $past(i_req_col)));

    assert_tgt_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        o_rsp_valid |-> (o_rsp_tgt != 2'd3));

    assert_data_unchanged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (o_rsp_valid && o_rsp_tgt == 2'd0) |->
            (o_rsp_bank == $past(i_req_bank) && o_rsp_row == $past(i_req_row)));

    assert_spare_row_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_rsp_valid && o_rsp_tgt == 2'd1) |->
            (o_rsp_bank == '0 && int'(o_rsp_row) < ROW_SPARES));

    assert_spare_bank_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (o_rsp_valid && o_rsp_tgt == 2'd2) |->
            (o_rsp_row == $past(i_req_row) && int'(o_rsp_bank) < BANK_SPARES));

    assert_row_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        o_row_exhausted |=> o_row_exhausted);

    assert_row_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_row_exhausted) |-> $past(i_flt_valid && i_flt_class <= 3'd2));

    assert_bank_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        o_bank_exhausted |=> o_bank_exhausted);

    assert_bank_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_bank_exhausted) |->
            $past(i_flt_valid && (i_flt_class == 3'd3 || i_flt_class == 3'd4)));

    assert_bad_class_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (i_flt_valid && i_flt_class > 3'd4) |=>
            ($stable(o_row_exhausted) && $stable(o_bank_exhausted)));

endmodule

bind dgs_remap_ctrl dgs_checker #(
    .BANK_W      (BANK_W),
    .ROW_W       (ROW_W),
    .COL_W       (COL_W),
    .ROW_SPARES  (ROW_SPARES),
    .BANK_SPARES (BANK_SPARES)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .i_flt_valid      (i_flt_valid),
    .i_flt_class      (i_flt_class),
    .i_flt_bank       (i_flt_bank),
    .i_flt_row        (i_flt_row),
    .i_req_valid      (i_req_valid),
    .i_req_bank       (i_req_bank),
    .i_req_row        (i_req_row),
    .i_req_col        (i_req_col),
    .o_rsp_valid      (o_rsp_valid),
    .o_rsp_tgt        (o_rsp_tgt),
    .o_rsp_bank       (o_rsp_bank),
    .o_rsp_row        (o_rsp_row),
    .o_rsp_col        (o_rsp_col),
    .o_row_exhausted  (o_row_exhausted),
    .o_bank_exhausted (o_bank_exhausted)
);

// File: tb/sim_dgs_remap_ctrl.sv
`timescale 1ns/1ps
// Bench for dgs_remap_ctrl: a vector table walked by one loop, then
// directed tests for pool exhaustion, reset and same-cycle ordering.
module sim_dgs_remap_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_flt_valid = 1'b0;
    logic [2:0] i_flt_class = '0;
    logic [3:0] i_flt_bank = '0;
    logic [7:0] i_flt_row = '0;
    logic       i_req_valid = 1'b0;
    logic [3:0] i_req_bank = '0;
    logic [7:0] i_req_row = '0;
    logic [5:0] i_req_col = '0;
    logic       o_rsp_valid;
    logic [1:0] o_rsp_tgt;
    logic [3:0] o_rsp_bank;
    logic [7:0] o_rsp_row;
    logic [5:0] o_rsp_col;
    logic       o_row_exhausted;
    logic       o_bank_exhausted;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dgs_remap_ctrl #(
        .BANK_W(4), .ROW_W(8), .COL_W(6), .ROW_SPARES(8), .BANK_SPARES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .i_flt_valid(i_flt_valid), .i_flt_class(i_flt_class),
        .i_flt_bank(i_flt_bank), .i_flt_row(i_flt_row),
        .i_req_valid(i_req_valid), .i_req_bank(i_req_bank),
        .i_req_row(i_req_row), .i_req_col(i_req_col),
        .o_rsp_valid(o_rsp_valid), .o_rsp_tgt(o_rsp_tgt),
        .o_rsp_bank(o_rsp_bank), .o_rsp_row(o_rsp_row), .o_rsp_col(o_rsp_col),
        .o_row_exhausted(o_row_exhausted), .o_bank_exhausted(o_bank_exhausted)
    );

    typedef struct packed {
        logic       is_req;
        logic [2:0] cls;
        logic [3:0] bank;
        logic [7:0] row;
        logic [5:0] col;
        logic [1:0] e_tgt;
        logic [3:0] e_bank;
        logic [7:0] e_row;
        logic       e_rx;
        logic       e_bx;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 4'd3,  8'd10,  6'd5,  2'd0, 4'd3,  8'd10,  1'b0, 1'b0}, // R2 unmapped
        '{1'b0, 3'd0, 4'd3,  8'd10,  6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // bit fault
        '{1'b1, 3'd0, 4'd3,  8'd10,  6'd7,  2'd1, 4'd0,  8'd0,   1'b0, 1'b0}, // R3 entry 0
        '{1'b1, 3'd0, 4'd3,  8'd11,  6'd1,  2'd0, 4'd3,  8'd11,  1'b0, 1'b0}, // R3 neighbour row
        '{1'b0, 3'd2, 4'd5,  8'd20,  6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // row fault
        '{1'b1, 3'd0, 4'd5,  8'd20,  6'd0,  2'd1, 4'd0,  8'd1,   1'b0, 1'b0}, // R3 entry 1
        '{1'b0, 3'd1, 4'd3,  8'd10,  6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // R7 duplicate
        '{1'b0, 3'd1, 4'd6,  8'd1,   6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // word fault
        '{1'b1, 3'd0, 4'd6,  8'd1,   6'd9,  2'd1, 4'd0,  8'd2,   1'b0, 1'b0}, // R7 entry 2
        '{1'b0, 3'd3, 4'd3,  8'd0,   6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // R4 column fault
        '{1'b1, 3'd0, 4'd3,  8'd10,  6'd2,  2'd2, 4'd0,  8'd10,  1'b0, 1'b0}, // R5 bank wins
        '{1'b1, 3'd0, 4'd3,  8'd200, 6'd4,  2'd2, 4'd0,  8'd200, 1'b0, 1'b0}, // R4 whole bank
        '{1'b0, 3'd0, 4'd3,  8'd44,  6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // R6 spared bank
        '{1'b0, 3'd0, 4'd7,  8'd7,   6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // R8 reuse
        '{1'b1, 3'd0, 4'd7,  8'd7,   6'd3,  2'd1, 4'd0,  8'd0,   1'b0, 1'b0}, // R8 R6 entry 0
        '{1'b0, 3'd5, 4'd8,  8'd8,   6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // R11 bad class
        '{1'b1, 3'd0, 4'd8,  8'd8,   6'd6,  2'd0, 4'd8,  8'd8,   1'b0, 1'b0}, // R11 untouched
        '{1'b0, 3'd4, 4'd9,  8'd0,   6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // bank fault
        '{1'b1, 3'd0, 4'd9,  8'd3,   6'd11, 2'd2, 4'd1,  8'd3,   1'b0, 1'b0}, // R4 spare 1
        '{1'b0, 3'd4, 4'd10, 8'd0,   6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // R10 no spare
        '{1'b1, 3'd0, 4'd10, 8'd3,   6'd12, 2'd0, 4'd10, 8'd3,   1'b0, 1'b1}, // R10 untranslated
        '{1'b0, 3'd3, 4'd6,  8'd0,   6'd0,  2'd0, 4'd0,  8'd0,   1'b0, 1'b0}, // R10 on row bank
        '{1'b1, 3'd0, 4'd6,  8'd1,   6'd13, 2'd1, 4'd0,  8'd2,   1'b0, 1'b1}  // R10 rows kept
    };

    // Compare the registered response against expected values
    task automatic check_rsp(input string tag, input logic [1:0] tgt,
                             input logic [3:0] bank, input logic [7:0] row,
                             input logic [5:0] col, input logic rx, input logic bx);
        n_checks++;
        if (o_rsp_valid !== 1'b1 || o_rsp_tgt !== tgt || o_rsp_bank !== bank ||
            o_rsp_row !== row || o_rsp_col !== col ||
            o_row_exhausted !== rx || o_bank_exhausted !== bx) begin
            n_fail++;
            $display("FAIL %s: v/tgt/bank/row/col/rx/bx got %0d/%0d/%0d/%0d/%0d/%0d/%0d exp 1/%0d/%0d/%0d/%0d/%0d/%0d",
                     tag, o_rsp_valid, o_rsp_tgt, o_rsp_bank, o_rsp_row, o_rsp_col,
                     o_row_exhausted, o_bank_exhausted, tgt, bank, row, col, rx, bx);
        end
    endtask

    // One-cycle fault report
    task automatic send_fault(input logic [2:0] cls, input logic [3:0] bank,
                              input logic [7:0] row);
        @(negedge clk);
        i_flt_valid = 1'b1; i_flt_class = cls; i_flt_bank = bank; i_flt_row = row;
        @(negedge clk);
        i_flt_valid = 1'b0;
    endtask

    // One-cycle request; the response is registered at the edge in between
    task automatic send_req(input logic [3:0] bank, input logic [7:0] row,
                            input logic [5:0] col);
        @(negedge clk);
        i_req_valid = 1'b1; i_req_bank = bank; i_req_row = row; i_req_col = col;
        @(negedge clk);
        i_req_valid = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_idle(input string tag);
        n_checks++;
        if (o_rsp_valid !== 1'b0 || o_row_exhausted !== 1'b0 || o_bank_exhausted !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: v/rx/bx got %0d/%0d/%0d exp 0/0/0",
                     tag, o_rsp_valid, o_row_exhausted, o_bank_exhausted);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_idle("R1 after reset");

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].is_req) begin
                send_req(VECS[k].bank, VECS[k].row, VECS[k].col);
                check_rsp($sformatf("table vector %0d", k), VECS[k].e_tgt, VECS[k].e_bank,
                          VECS[k].e_row, VECS[k].col, VECS[k].e_rx, VECS[k].e_bx);
            end else begin
                send_fault(VECS[k].cls, VECS[k].bank, VECS[k].row);
            end
        end

        // Fill the five free row entries (3..7) in bank 11
        for (int r = 0; r < 5; r++) send_fault(3'd0, 4'd11, 8'(r));
        send_req(4'd11, 8'd4, 6'd20);
        check_rsp("R3 last free entry", 2'd1, 4'd0, 8'd7, 6'd20, 1'b0, 1'b1);
        send_req(4'd11, 8'd0, 6'd21);
        check_rsp("R3 lowest free after reuse", 2'd1, 4'd0, 8'd3, 6'd21, 1'b0, 1'b1);

        // One more small fault with the pool full
        send_fault(3'd2, 4'd11, 8'd5);
        send_req(4'd11, 8'd5, 6'd22);
        check_rsp("R9 row pool exhausted", 2'd0, 4'd11, 8'd5, 6'd22, 1'b1, 1'b1);
        send_req(4'd5, 8'd20, 6'd23);
        check_rsp("R9 existing entry kept", 2'd1, 4'd0, 8'd1, 6'd23, 1'b1, 1'b1);

        // Reset clears everything
        apply_reset();
        check_idle("R1 mid-run reset");
        send_req(4'd7, 8'd7, 6'd24);
        check_rsp("R1 table cleared", 2'd0, 4'd7, 8'd7, 6'd24, 1'b0, 1'b0);

        // Fault and request in the same cycle
        @(negedge clk);
        i_flt_valid = 1'b1; i_flt_class = 3'd0; i_flt_bank = 4'd2; i_flt_row = 8'd2;
        i_req_valid = 1'b1; i_req_bank = 4'd2; i_req_row = 8'd2; i_req_col = 6'd25;
        @(negedge clk);
        i_flt_valid = 1'b0; i_req_valid = 1'b0;
        check_rsp("R12 old table seen", 2'd0, 4'd2, 8'd2, 6'd25, 1'b0, 1'b0);
        send_req(4'd2, 8'd2, 6'd26);
        check_rsp("R12 new table next", 2'd1, 4'd0, 8'd0, 6'd26, 1'b0, 1'b0);

        // Response lasts a single cycle
        @(negedge clk);
        n_checks++;
        if (o_rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 single-cycle response: got %0d exp 0", o_rsp_valid);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule